// File: doc/BRIEF.md
# CAN Controller Mode Supervisor

This block holds the operating-mode decision for a CAN controller. It takes the configuration bits that software writes: module disable, halt, freeze enable, loop-back, listen-only, warning enable and self-reception disable. From these it settles on one of five modes: Normal, Listen-Only, Loop-Back, Freeze or Disable. It drives the read-only acknowledge flags and the not-ready flag that software polls.

A freeze or disable request is only acknowledged once the bus is quiet, so a frame in progress is never cut off. The block also compares the transmit and receive error counters against a warning level of 96 and keeps a sticky warning flag for each. It tells the rest of the controller whether transmission and reception are allowed. It decides whether a frame the node sent itself is handed back to its own receiver, and it keeps such a frame away from buffer storage.

Top module: `can_mode_sup`

## Requirements
- R1: Freeze is acknowledged (`frz_ack`=1, `mode`=3) only when both `cfg_halt` and `cfg_frz_en` are 1. The flag rises one clock edge after the request, provided `frame_active` is 0.
- R2: Once either `cfg_halt` or `cfg_frz_en` is 0, `frz_ack` is 0 after the next clock edge, even while `frame_active` is 1.
- R3: While `frame_active` is 1, a new freeze or disable request is not acknowledged. It is acknowledged on the edge after `frame_active` returns to 0. A flag already acknowledged stays set while a frame is active.
- R4: `not_ready` is 1 exactly in Freeze (`mode`=3) and Disable (`mode`=4), and 0 in Normal, Listen-Only and Loop-Back.
- R5: `cfg_disable` acknowledges Disable (`lpm_ack`=1, `mode`=4) one edge later when the bus is idle. It takes priority over a freeze request, so `frz_ack` and `lpm_ack` are never both 1. `lpm_ack` clears one edge after `cfg_disable` is removed.
- R6: Among the active modes, `cfg_loopback` gives `mode`=2 and takes priority over `cfg_listen`, which gives `mode`=1. With neither set, `mode`=0.
- R7: `tx_allowed` is 1 only in modes 0 and 2. `rx_allowed` is 1 only in modes 0, 1 and 2.
- R8: With `cfg_warn_en`=1, a warning flag is set on the edge after its error counter moves from 96 or below to above 96. With `cfg_warn_en`=0, that crossing leaves the flag unchanged.
- R9: Warning flags are sticky. A 1 on `tx_warn_clr` or `rx_warn_clr` clears the flag at the next edge. A counter that merely stays above 96 does not set the flag again. A set and a clear in the same cycle leave the flag set.
- R10: `self_loop_rx` equals `self_tx_done` AND NOT `cfg_selfrx_off` AND `rx_allowed`. It is combinational.
- R11: `rx_store` is 1 only for `rx_done` with `rx_match` in a mode that allows reception, and never when `rx_is_self` is 1. It is combinational.
- R12: After reset, `mode`=0, both acknowledges are 0 and both warning flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disable | input | 1 | Module disable request |
| cfg_halt | input | 1 | Halt request |
| cfg_frz_en | input | 1 | Freeze enable |
| cfg_loopback | input | 1 | Loop-back select |
| cfg_listen | input | 1 | Listen-only select |
| cfg_warn_en | input | 1 | Warning flag enable |
| cfg_selfrx_off | input | 1 | 1 stops own frames reaching the receiver |
| frame_active | input | 1 | A frame is on the bus |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| tx_warn_clr | input | 1 | Write-1 clear of the transmit warning |
| rx_warn_clr | input | 1 | Write-1 clear of the receive warning |
| self_tx_done | input | 1 | Own frame finished transmitting |
| rx_done | input | 1 | A received frame is complete |
| rx_match | input | 1 | The received ID passed filtering |
| rx_is_self | input | 1 | The received frame is the node's own |
| mode | output | 3 | Current mode: 0 Normal, 1 Listen, 2 Loop-Back, 3 Freeze, 4 Disable |
| frz_ack | output | 1 | Freeze reached |
| lpm_ack | output | 1 | Disable reached |
| not_ready | output | 1 | Module is in Freeze or Disable |
| tx_warn | output | 1 | Sticky transmit warning |
| rx_warn | output | 1 | Sticky receive warning |
| tx_allowed | output | 1 | Transmission permitted |
| rx_allowed | output | 1 | Reception permitted |
| self_loop_rx | output | 1 | Deliver own frame to the receiver |
| rx_store | output | 1 | Store the frame and raise the receive interrupt |

## Verification
The acknowledges, `mode`, `not_ready` and the gating outputs that follow them change one edge after a request reaches the inputs. The warning flags likewise move one edge after a counter crossing or a clear. The bench drives on the falling edge and samples on the next falling edge, after exactly one rising edge. `self_loop_rx` and `rx_store` are combinational in the current mode and inputs. They are sampled a short delay after the drive, inside the same half period. The bench models the warning comparator with its own record of the previous counter level, updated once per edge.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_LISTEN   = 3'd1,
    MODE_LOOPBACK = 3'd2,
    MODE_FREEZE   = 3'd3,
    MODE_DISABLE  = 3'd4
  } mode_e;

  // Priority: disable, freeze, loop-back, listen-only, normal
  function automatic mode_e pick_mode(input logic lpm, input logic frz,
                                      input logic lb, input logic lo);
    if (lpm)      return MODE_DISABLE;
    else if (frz) return MODE_FREEZE;
    else if (lb)  return MODE_LOOPBACK;
    else if (lo)  return MODE_LISTEN;
    else          return MODE_NORMAL;
  endfunction
endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dis_req,
  input  logic  frz_req,
  input  logic  frame_active,
  input  logic  lb,
  input  logic  lo,
  output logic  frz_ack,
  output logic  lpm_ack,
  output mode_e mode
);
  logic lpm_nxt, frz_nxt;

  // A new acknowledge waits for an idle bus; an existing one holds.
  always_comb begin
    lpm_nxt = dis_req & (lpm_ack | ~frame_active);
    frz_nxt = frz_req & ~dis_req & ~lpm_nxt & (frz_ack | ~frame_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpm_ack <= 1'b0;
      frz_ack <= 1'b0;
    end else begin
      lpm_ack <= lpm_nxt;
      frz_ack <= frz_nxt;
    end
  end

  assign mode = pick_mode(lpm_ack, frz_ack, lb, lo);
endmodule

// File: rtl/can_err_warn.sv
module can_err_warn #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             warn_en,
  input  logic             clr,
  output logic             flag,
  output logic             crossing
);
  function automatic logic above(input logic [CNT_W-1:0] v);
    return int'(v) > LIMIT;
  endfunction

  logic above_q;
  assign crossing = above(cnt) & ~above_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      above_q <= above(cnt);
      if (crossing && warn_en) flag <= 1'b1;
      else if (clr)            flag <= 1'b0;
    end
  end
endmodule

// File: rtl/can_traffic_gate.sv
module can_traffic_gate
  import can_mode_pkg::*;
(
  input  mode_e mode,
  input  logic  selfrx_off,
  input  logic  self_tx_done,
  input  logic  rx_done,
  input  logic  rx_match,
  input  logic  rx_is_self,
  output logic  tx_allowed,
  output logic  rx_allowed,
  output logic  self_loop_rx,
  output logic  rx_store
);
  always_comb begin
    tx_allowed   = (mode == MODE_NORMAL) || (mode == MODE_LOOPBACK);
    rx_allowed   = (mode == MODE_NORMAL) || (mode == MODE_LISTEN) ||
                   (mode == MODE_LOOPBACK);
    self_loop_rx = self_tx_done & ~selfrx_off & rx_allowed;
    rx_store     = rx_done & rx_match & ~rx_is_self & rx_allowed;
  end
endmodule

// File: rtl/can_mode_sup.sv
module can_mode_sup
  import can_mode_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_disable,
  input  logic             cfg_halt,
  input  logic             cfg_frz_en,
  input  logic             cfg_loopback,
  input  logic             cfg_listen,
  input  logic             cfg_warn_en,
  input  logic             cfg_selfrx_off,
  input  logic             frame_active,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             tx_warn_clr,
  input  logic             rx_warn_clr,
  input  logic             self_tx_done,
  input  logic             rx_done,
  input  logic             rx_match,
  input  logic             rx_is_self,
  output logic [2:0]       mode,
  output logic             frz_ack,
  output logic             lpm_ack,
  output logic             not_ready,
  output logic             tx_warn,
  output logic             rx_warn,
  output logic             tx_allowed,
  output logic             rx_allowed,
  output logic             self_loop_rx,
  output logic             rx_store
);
  localparam int NCNT = 2;

  mode_e            mode_w;
  logic             frz_req;
  logic [CNT_W-1:0] cnt_a [NCNT];
  logic [NCNT-1:0]  clr_a, flag_a, cross_a;

  assign frz_req = cfg_halt & cfg_frz_en;

  can_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dis_req(cfg_disable), .frz_req(frz_req),
    .frame_active(frame_active), .lb(cfg_loopback), .lo(cfg_listen),
    .frz_ack(frz_ack), .lpm_ack(lpm_ack), .mode(mode_w)
  );

  assign mode      = mode_w;
  assign not_ready = frz_ack | lpm_ack;

  assign cnt_a[0] = tx_err_cnt;
  assign cnt_a[1] = rx_err_cnt;
  assign clr_a    = {rx_warn_clr, tx_warn_clr};

  for (genvar i = 0; i < NCNT; i++) begin : g_warn
    can_err_warn #(.CNT_W(CNT_W), .LIMIT(WARN_LIMIT)) u_warn (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_a[i]), .warn_en(cfg_warn_en),
      .clr(clr_a[i]), .flag(flag_a[i]), .crossing(cross_a[i])
    );
  end

  assign tx_warn = flag_a[0];
  assign rx_warn = flag_a[1];

  can_traffic_gate u_gate (
    .mode(mode_w), .selfrx_off(cfg_selfrx_off), .self_tx_done(self_tx_done),
    .rx_done(rx_done), .rx_match(rx_match), .rx_is_self(rx_is_self),
    .tx_allowed(tx_allowed), .rx_allowed(rx_allowed),
    .self_loop_rx(self_loop_rx), .rx_store(rx_store)
  );
endmodule

// File: rtl/can_mode_sup_chk.sv
module can_mode_sup_chk #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_disable,
  input logic             cfg_halt,
  input logic             cfg_frz_en,
  input logic             cfg_warn_en,
  input logic             frame_active,
  input logic [CNT_W-1:0] tx_err_cnt,
  input logic             rx_is_self,
  input logic [2:0]       mode,
  input logic             frz_ack,
  input logic             lpm_ack,
  input logic             not_ready,
  input logic             tx_warn,
  input logic             tx_allowed,
  input logic             rx_allowed,
  input logic             rx_store
);
  AST_FRZ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_halt && cfg_frz_en) |=> !frz_ack);                              // R2
  AST_ACK_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(!frame_active && cfg_halt && cfg_frz_en));   // R3
  AST_NOTRDY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready == (mode == 3'd3 || mode == 3'd4));                         // R4
  AST_DIS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !(lpm_ack && frz_ack));                                               // R5
  AST_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready |-> (!tx_allowed && !rx_allowed));                          // R7
  AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_warn) |-> $past(cfg_warn_en && int'(tx_err_cnt) > WARN_LIMIT)); // R8
  AST_SELF_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_is_self |-> !rx_store);                                            // R11
  AST_DIS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_disable |=> !lpm_ack);                                           // R5
endmodule

bind can_mode_sup can_mode_sup_chk #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_halt(cfg_halt),
  .cfg_frz_en(cfg_frz_en), .cfg_warn_en(cfg_warn_en), .frame_active(frame_active),
  .tx_err_cnt(tx_err_cnt), .rx_is_self(rx_is_self), .mode(mode),
  .frz_ack(frz_ack), .lpm_ack(lpm_ack), .not_ready(not_ready), .tx_warn(tx_warn),
  .tx_allowed(tx_allowed), .rx_allowed(rx_allowed), .rx_store(rx_store)
);

// File: tb/can_mode_sup_tb.sv
`timescale 1ns/1ps
module can_mode_sup_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_disable = 0, cfg_halt = 0, cfg_frz_en = 0, cfg_loopback = 0, cfg_listen = 0;
  logic cfg_warn_en = 0, cfg_selfrx_off = 0, frame_active = 0;
  logic [7:0] tx_err_cnt = 0, rx_err_cnt = 0;
  logic tx_warn_clr = 0, rx_warn_clr = 0, self_tx_done = 0, rx_done = 0, rx_match = 0, rx_is_self = 0;
  logic [2:0] mode;
  logic frz_ack, lpm_ack, not_ready, tx_warn, rx_warn, tx_allowed, rx_allowed, self_loop_rx, rx_store;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_mode_sup u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_mode(input bit d, h, f, lb, lo);
    if (d) return 4;
    if (h && f) return 3;
    if (lb) return 2;
    if (lo) return 1;
    return 0;
  endfunction

  // warning model: previous-above record per counter
  bit prev_above, model_flag;
  task automatic warn_step(input int v, input bit en, input bit clr, input string req);
    bit ab;
    tx_err_cnt = 8'(v); cfg_warn_en = en; tx_warn_clr = clr;
    rx_err_cnt = 8'(v); rx_warn_clr = clr;
    ab = v > 96;
    if (ab && !prev_above && en) model_flag = 1;
    else if (clr) model_flag = 0;
    prev_above = ab;
    step();
    chk({req, " tx_warn"}, tx_warn, model_flag);
    chk({req, " rx_warn"}, rx_warn, model_flag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) step();
    // R12 reset state
    chk("R12 mode", mode, 0); chk("R12 frz_ack", frz_ack, 0);
    chk("R12 lpm_ack", lpm_ack, 0); chk("R12 tx_warn", tx_warn, 0); chk("R12 rx_warn", rx_warn, 0);
    rst_n = 1; step();

    // R1 R4 R5 R6 R7: sweep all request combinations with an idle bus
    for (int c = 0; c < 32; c++) begin
      int em;
      cfg_disable = c[4]; cfg_halt = c[3]; cfg_frz_en = c[2];
      cfg_loopback = c[1]; cfg_listen = c[0];
      step();
      em = exp_mode(c[4], c[3], c[2], c[1], c[0]);
      chk("R6 mode", mode, em);
      chk("R1 frz_ack", frz_ack, em == 3);
      chk("R5 lpm_ack", lpm_ack, em == 4);
      chk("R4 not_ready", not_ready, em >= 3);
      chk("R7 tx_allowed", tx_allowed, em == 0 || em == 2);
      chk("R7 rx_allowed", rx_allowed, em <= 2);
    end
    cfg_disable = 0; cfg_halt = 0; cfg_frz_en = 0; cfg_loopback = 0; cfg_listen = 0;
    step(); chk("R2 idle", mode, 0);

    // R3: freeze request during a frame waits for idle
    frame_active = 1; cfg_halt = 1; cfg_frz_en = 1;
    for (int k = 0; k < 4; k++) begin step(); chk("R3 frz wait", frz_ack, 0); end
    frame_active = 0; step(); chk("R3 frz after idle", frz_ack, 1);
    frame_active = 1; step(); chk("R3 frz holds", frz_ack, 1);
    // R2: exit during a frame, one edge after clearing
    cfg_frz_en = 0; step(); chk("R2 frz exit", frz_ack, 0); chk("R2 mode", mode, 0);
    cfg_frz_en = 1; step(); chk("R3 rereq wait", frz_ack, 0);
    cfg_halt = 0; cfg_frz_en = 0;
    // R3 disable waits too
    cfg_disable = 1; step(); chk("R3 lpm wait", lpm_ack, 0);
    frame_active = 0; step(); chk("R3 lpm after idle", lpm_ack, 1);
    cfg_disable = 0; frame_active = 1; step(); chk("R5 lpm exit", lpm_ack, 0);
    frame_active = 0; step();

    // R8 R9: warning sweeps
    prev_above = 0; model_flag = 0;
    for (int v = 90; v <= 100; v++) warn_step(v, 1, 0, "R8 rise");
    for (int v = 100; v <= 110; v++) warn_step(v, 1, 0, "R9 hold");
    warn_step(110, 1, 1, "R9 clear");
    for (int k = 0; k < 3; k++) warn_step(120, 1, 0, "R9 no reset while above");
    warn_step(96, 1, 0, "R8 at limit");
    warn_step(97, 0, 0, "R8 disabled");
    warn_step(96, 0, 0, "R8 down");
    warn_step(97, 1, 1, "R9 set wins");
    warn_step(50, 1, 1, "R9 clear2");
    for (int v = 0; v < 256; v += 7) warn_step(v, v[3], v[4] & v[1], "R8 sweep");

    // R10 R11: combinational gating in several modes
    for (int m = 0; m < 4; m++) begin
      int em;
      cfg_disable = (m == 3); cfg_halt = (m == 2); cfg_frz_en = (m == 2); cfg_listen = (m == 1);
      step();
      em = (m == 3) ? 4 : (m == 2) ? 3 : (m == 1) ? 1 : 0;
      chk("R6 gate mode", mode, em);
      for (int c = 0; c < 32; c++) begin
        bit ra;
        self_tx_done = c[0]; cfg_selfrx_off = c[1]; rx_done = c[2]; rx_match = c[3]; rx_is_self = c[4];
        #1;
        ra = em <= 2;
        chk("R10 self_loop_rx", self_loop_rx, c[0] && !c[1] && ra);
        chk("R11 rx_store", rx_store, c[2] && c[3] && !c[4] && ra);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule